// File: doc/BRIEF.md
# Sliding-Window Dictionary Match Engine

This block is the matching core of a byte-stream dictionary compressor. It keeps the most recent bytes of the stream in a window that can be searched by content. Each arriving byte is compared in one cycle against every filled window position, which yields a per-position hit vector. A candidate vector holds every position whose earlier content still agrees with the bytes seen so far in the current match. On each new byte the candidate vector is ANDed with that byte's hit vector. The match ends when no candidate survives, when the programmed length cap is reached, or when the stream ends. The surviving position nearest to the present is then reported.

Every result leaves as one fixed-width token on a valid/ready output. A token is either a single literal byte or a distance/length pair. A match shorter than three bytes is not worth a pair, so it is released as literals in stream order. Input bytes arrive on a valid/ready port with an end-of-stream flag. After the final byte, any open match is flushed and the window is emptied, so the next stream starts with no history.

Top module: `lzcam_core`

## Requirements
- R1: After reset `tok_valid` is 0 and `in_ready` is 1 while no input is offered.
- R2: A byte that equals no filled window position is emitted at once as a literal token: bit TOKW-1 = 0, bits [7:0] = the byte, all other bits 0.
- R3: A run of three or more bytes that repeats earlier bytes of the same stream is emitted as one match token: bit TOKW-1 = 1, bits [OFFW+LENW-1:LENW] = distance minus one, bits [LENW-1:0] = length. Distance 1 means the byte just before.
- R4: The reported length is the longest available at the match start, up to the cap. When several distances reach that length, the smallest distance is reported.
- R5: A match that ends at one or two bytes is emitted as that many literal tokens, oldest byte first. The next byte starts a fresh search.
- R6: A match is closed when its length equals `max_len`, and the following byte starts a fresh search. With `max_len` below 3 every token is a literal.
- R7: A match may overlap the bytes it copies (distance smaller than length), for example a run of one repeated byte.
- R8: After the byte flagged `in_last`, any open match is flushed and the window is emptied. No byte of a later stream matches an earlier stream, and no token appears while idle.
- R9: While `tok_valid` is high and `tok_ready` is low, `tok_data` holds, `in_ready` is low, and no byte is lost.
- R10: Only the last WIN bytes can be matched. Distance WIN still matches, and distance WIN+1 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Core accepts the offered byte this cycle |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Offered byte is the last of its stream |
| max_len | input | LENW | Length cap for a match |
| tok_valid | output | 1 | Token available |
| tok_ready | input | 1 | Downstream accepts the token |
| tok_data | output | 1+OFFW+LENW | Token: flag, then distance-1 and length, or a zero-padded literal |

## Verification
The bench goes after several corner cases. The first is the window edge at distances WIN and WIN+1: an off-by-one there would either drop a legal match or report one into flushed history. Ties between equal-length candidates are checked, where a reversed priority encoder would report the older distance. Short matches broken by a mismatch or by end of stream are checked, where a wrong flush order would swap or lose literals. Self-overlapping runs at several length caps are checked, where a wrong cap comparison would give lengths one too long or too short. Back-to-back streams expose a window that is not cleared. Irregular back-pressure on the output exposes tokens that change or bytes that are taken while the core is stalled.

// File: rtl/lzcam_core.sv
module lzcam_core #(
  parameter int WIN  = 2048,
  parameter int LENW = 8,
  localparam int OFFW = $clog2(WIN),
  localparam int TOKW = 1 + OFFW + LENW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  input  logic [LENW-1:0] max_len,
  output logic            tok_valid,
  input  logic            tok_ready,
  output logic [TOKW-1:0] tok_data
);
  localparam int PADW = OFFW + LENW - 8;

  logic [7:0]      hist [WIN];
  logic [WIN-1:0]  vld, act, hit;
  logic [LENW-1:0] mlen;
  logic            closing, ending;
  logic [OFFW-1:0] best;
  logic            adv, cont, any_hit, close_c, take;
  logic [7:0]      old_byte;

  genvar g;
  generate
    for (g = 0; g < WIN; g++) begin : g_cmp
      assign hit[g] = vld[g] && (hist[g] == in_data);
    end
  endgenerate

  always_comb begin
    best = '0;
    for (int i = WIN - 1; i >= 0; i--)
      if (act[i]) best = OFFW'(i);
  end

  assign adv      = !tok_valid || tok_ready;
  assign cont     = |(act & hit);
  assign any_hit  = |hit;
  assign close_c  = (mlen != '0) &&
                    (closing || ending || (mlen >= max_len) || (in_valid && !cont));
  assign in_ready = adv && !close_c && !ending;
  assign take     = in_valid && in_ready;
  assign old_byte = hist[mlen[1:0] - 2'd1];

  always_ff @(posedge clk) begin
    if (take) begin
      hist[0] <= in_data;
      for (int i = 1; i < WIN; i++) hist[i] <= hist[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_valid <= 1'b0;
      tok_data  <= '0;
      mlen      <= '0;
      act       <= '0;
      vld       <= '0;
      closing   <= 1'b0;
      ending    <= 1'b0;
    end else begin
      if (tok_ready) tok_valid <= 1'b0;
      if (adv) begin
        if (close_c) begin
          tok_valid <= 1'b1;
          if (mlen >= LENW'(3)) begin
            tok_data <= {1'b1, best, mlen};
            mlen     <= '0;
            closing  <= 1'b0;
          end else begin
            tok_data <= {1'b0, {PADW{1'b0}}, old_byte};
            mlen     <= mlen - LENW'(1);
            closing  <= 1'b1;
          end
        end else if (ending && mlen == '0) begin
          ending <= 1'b0;
          vld    <= '0;
        end else if (take) begin
          vld     <= {vld[WIN-2:0], 1'b1};
          ending  <= in_last;
          closing <= 1'b0;
          if (mlen == '0) begin
            if (any_hit) begin
              act  <= hit;
              mlen <= LENW'(1);
            end else begin
              tok_valid <= 1'b1;
              tok_data  <= {1'b0, {PADW{1'b0}}, in_data};
            end
          end else begin
            act  <= act & hit;
            mlen <= mlen + LENW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/lzcam_core_chk.sv
module lzcam_core_chk #(
  parameter int WIN  = 2048,
  parameter int LENW = 8,
  localparam int OFFW = $clog2(WIN),
  localparam int TOKW = 1 + OFFW + LENW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic [LENW-1:0] max_len,
  input logic            tok_valid,
  input logic            tok_ready,
  input logic [TOKW-1:0] tok_data
);
  AST_TOK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !tok_ready |=> tok_valid && $stable(tok_data)); // R9
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !tok_ready |-> !in_ready); // R9
  AST_MATCH_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_data[TOKW-1] |-> tok_data[LENW-1:0] >= LENW'(3)); // R5
  AST_MATCH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && tok_data[TOKW-1] |-> tok_data[LENW-1:0] <= max_len); // R6
  AST_LIT_PADDING: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid && !tok_data[TOKW-1] |-> tok_data[TOKW-2:8] == '0); // R2
endmodule

bind lzcam_core lzcam_core_chk #(.WIN(WIN), .LENW(LENW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .max_len(max_len),
  .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_data(tok_data)
);

// File: tb/lzcam_core_test.sv
module lzcam_core_test;
  localparam int WIN  = 16;
  localparam int LENW = 8;
  localparam int OFFW = 4;
  localparam int TOKW = 1 + OFFW + LENW;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, tok_ready = 1;
  logic [7:0] in_data = 0;
  logic [LENW-1:0] max_len = 8'd16;
  logic in_ready, tok_valid;
  logic [TOKW-1:0] tok_data;

  lzcam_core #(.WIN(WIN), .LENW(LENW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .max_len(max_len),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .tok_data(tok_data));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] s [64];
  int n;
  logic [TOKW-1:0] expt [64];
  int ne;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      bad++; total++;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exv);
    end
  endtask

  function automatic logic [TOKW-1:0] lit(input logic [7:0] b);
    return {1'b0, {(TOKW-9){1'b0}}, b};
  endfunction

  task automatic build_exp(input int ml);
    int i, bl, bd, k;
    i = 0; ne = 0;
    while (i < n) begin
      bl = 0; bd = 0;
      for (int d = 1; d <= i && d <= WIN; d++) begin
        k = 0;
        while (k < ml && i + k < n && s[i+k] == s[i+k-d]) k++;
        if (k > bl) begin bl = k; bd = d; end
      end
      if (bl >= 3) begin
        expt[ne] = {1'b1, OFFW'(bd - 1), LENW'(bl)}; ne++; i += bl;
      end else if (bl == 0) begin
        expt[ne] = lit(s[i]); ne++; i++;
      end else begin
        for (int t = 0; t < bl; t++) begin expt[ne] = lit(s[i+t]); ne++; end
        i += bl;
      end
    end
  endtask

  task automatic set_str(input string str);
    n = str.len();
    for (int i = 0; i < n; i++) s[i] = str[i];
  endtask

  task automatic run_stream(input int ml, input bit stall, input string tag);
    int idx, got, guard;
    bit held;
    logic [TOKW-1:0] hv;
    build_exp(ml);
    max_len = LENW'(ml);
    idx = 0; got = 0; guard = 0; held = 0; hv = '0;
    while ((idx < n || got < ne) && guard < 4000) begin
      @(negedge clk);
      if (held) chk(tok_valid && tok_data == hv, {tag, "/R9 hold"}, 32'(tok_data), 32'(hv));
      in_valid  = (idx < n);
      in_data   = s[idx < n ? idx : 0];
      in_last   = (idx == n - 1);
      tok_ready = !(stall && (guard % 3 == 1));
      #1;
      if (tok_valid && !tok_ready)
        chk(!in_ready, {tag, "/R9 ready"}, 32'(in_ready), 32'd0);
      held = tok_valid && !tok_ready;
      hv = tok_data;
      if (in_valid && in_ready) idx++;
      if (tok_valid && tok_ready) begin
        if (got < ne) chk(tok_data == expt[got], tag, 32'(tok_data), 32'(expt[got]));
        else chk(1'b0, {tag, " extra token"}, 32'(tok_data), 32'd0);
        got++;
      end
      guard++;
    end
    chk(got == ne && idx == n, {tag, " count"}, 32'(got), 32'(ne));
    @(negedge clk);
    in_valid = 0; in_last = 0; tok_ready = 1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk(!tok_valid, {tag, "/R8 idle"}, 32'(tok_valid), 32'd0);
    end
  endtask

  initial begin
    int seedv;
    repeat (3) @(negedge clk);
    chk(!tok_valid && in_ready, "R1", {30'd0, tok_valid, in_ready}, 32'd1);
    rst_n = 1;
    @(negedge clk);
    chk(!tok_valid && in_ready, "R1", {30'd0, tok_valid, in_ready}, 32'd1);

    set_str("abcdefgh");     run_stream(16, 0, "R2");
    set_str("abcdabcd");     run_stream(16, 0, "R3");
    set_str("abcxabcyabc");  run_stream(16, 0, "R4");
    set_str("abxab");        run_stream(16, 0, "R5");
    set_str("abxaby");       run_stream(16, 1, "R5");
    set_str("aaaaaaaaaa");   run_stream(3, 0, "R6");
    set_str("abcabcabc");    run_stream(2, 0, "R6");
    set_str("aaaaa");        run_stream(16, 0, "R7");
    set_str("abcd");         run_stream(16, 0, "R8");
    set_str("abcd");         run_stream(16, 0, "R8");

    n = 20;
    s[0] = "x"; s[1] = "y"; s[2] = "z";
    for (int i = 3; i < 17; i++) s[i] = 8'h30 + 8'(i);
    s[17] = "x"; s[18] = "y"; s[19] = "z";
    run_stream(16, 0, "R10");
    n = 19;
    for (int i = 3; i < 16; i++) s[i] = 8'h30 + 8'(i);
    s[16] = "x"; s[17] = "y"; s[18] = "z";
    run_stream(16, 1, "R10");

    for (int ml = 0; ml <= 8; ml++) begin
      for (int sd = 0; sd < 6; sd++) begin
        seedv = sd * 7919 + ml * 31 + 1;
        n = 40;
        for (int i = 0; i < n; i++) begin
          seedv = seedv * 1103515245 + 12345;
          s[i] = 8'h61 + 8'(((seedv >>> 16) & 32'h7fff) % 3);
        end
        run_stream(ml, sd[0], "R4_R6_R7_sweep");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule